// File: doc/BRIEF.md
# Conflict-Set Bank Predictor

This block learns which static memory instructions have collided on a cache bank and keeps them apart at issue. A direct-mapped table, indexed by low instruction-address bits, gives each instruction an optional set identifier. When the memory pipeline reports that two instructions collided on a bank, the block places both instructions in one shared set. Whenever a reported pair joins two existing sets, the smaller identifier wins. Each set behaves like a connected component of the observed conflict graph, but it uses bounded storage.

The issue stage presents up to `ISSUE_W` candidate memory operations per cycle, oldest in slot 0. A candidate is held back when an older candidate in the same cycle has already been granted and both belong to the same set. The held operation is retried later, so no bank-conflict restart occurs. A lookup port exposes the table entry of any instruction address. A free-running sweep wipes the whole table periodically so that old sets cannot grow without limit.

Top module: `cset_predictor`

## Requirements
- R1: After reset, every entry is empty: a lookup returns valid 0 and identifier 0, and every valid issue candidate is granted.
- R2: A training pair in which neither instruction has a set takes the current value of the allocation counter (0 after reset) and writes it to both entries. The counter then advances.
- R3: A training pair in which exactly one instruction has a set writes that identifier to the other instruction's entry. The counter does not advance.
- R4: A training pair in which both instructions have sets writes the numerically smaller identifier to both entries. Other entries holding the larger identifier are left unchanged.
- R5: Issue slot k is granted when it is valid and no lower-numbered granted slot has a set equal to its own. A slot with no set is always granted, and so is a valid slot 0.
- R6: An invalid issue slot is never granted and never holds back another slot.
- R7: Lookups and issue checks in the same cycle as a training pair see the table contents from before that pair. The update becomes visible one cycle later.
- R8: The 7-bit allocation counter wraps from 127 to 0.
- R9: On the 65536th clock edge after reset release, and every 65536 edges after that, all entries become empty and the allocation counter returns to 0. A training pair presented in that cycle is discarded.
- R10: The table index is instruction-address bits [11:2]. Addresses that agree in those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc_i | input | PC_W | Instruction address to look up |
| lk_vld_o | output | 1 | Looked-up instruction belongs to a set |
| lk_sid_o | output | SID_W | Set identifier of the looked-up instruction (0 when empty) |
| trn_vld_i | input | 1 | A bank conflict between two instructions is reported |
| trn_pc_a_i | input | PC_W | First instruction of the conflicting pair |
| trn_pc_b_i | input | PC_W | Second instruction of the conflicting pair |
| iss_vld_i | input | ISSUE_W | Candidate present per issue slot (slot 0 oldest) |
| iss_pc_i | input | ISSUE_W*PC_W | Candidate instruction addresses, slot k at bits [k*PC_W +: PC_W] |
| iss_go_o | output | ISSUE_W | Candidate granted this cycle (0 = held back) |

## Verification
A wrong identifier or valid bit in the table appears on the lookup port in the cycle after the training pair that wrote it. The same fault appears on the grant vector as soon as two instructions of the affected set meet in one issue group. A merge that picks the larger identifier, or that rewrites other members, shows up as an unexpected identifier on the next lookup. It also shows up as a grant that should have been a hold. A misplaced sweep leaves entries valid after edge 65536, or it empties them early. A counter that does not restart or wrap is caught by the identifiers of fresh sets allocated after the sweep.

// File: rtl/cset_pkg.sv
// Shared types for the conflict-set predictor.
// Assumes nothing beyond standard SystemVerilog packages.
package cset_pkg;

    // Which kind of table update a reported conflict pair causes
    typedef enum logic [1:0] {
        TRN_NEW     = 2'd0,   // neither side has a set: allocate
        TRN_ADOPT_A = 2'd1,   // only side A has a set: B joins it
        TRN_ADOPT_B = 2'd2,   // only side B has a set: A joins it
        TRN_MERGE   = 2'd3    // both sides have sets: keep the smaller id
    } trn_case_e;

endpackage

// File: rtl/cset_table.sv
// Direct-mapped set table: one valid bit and one set identifier per entry.
// Provides NRD combinational read ports and a dual-index write that
// stores the same identifier into two entries in one cycle.
// Assumes: the clear input overrides any write in the same cycle; reads
// return the contents from before the current clock edge.
module cset_table #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned SID_W = 7,
    parameter int unsigned NRD   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic [NRD*IDX_W-1:0]   rd_idx_i,
    output logic [NRD-1:0]         rd_vld_o,
    output logic [NRD*SID_W-1:0]   rd_sid_o,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_a_i,
    input  logic [IDX_W-1:0]       wr_idx_b_i,
    input  logic [SID_W-1:0]       wr_sid_i
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [SID_W-1:0] sid_q [DEPTH];

    // Valid bits: reset and sweep empty the table, a write marks both entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_a_i] <= 1'b1;
            vld_q[wr_idx_b_i] <= 1'b1;
        end
    end

    // Identifier storage: no reset needed, gated by the valid bit on read
    always_ff @(posedge clk) begin
        if (wr_en_i && !clr_i) begin
            sid_q[wr_idx_a_i] <= wr_sid_i;
            sid_q[wr_idx_b_i] <= wr_sid_i;
        end
    end

    // One combinational read port per requester
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [IDX_W-1:0] idx;
        assign idx = rd_idx_i[p*IDX_W +: IDX_W];
        assign rd_vld_o[p] = vld_q[idx];
        assign rd_sid_o[p*SID_W +: SID_W] = vld_q[idx] ? sid_q[idx] : '0;
    end

endmodule

// File: rtl/cset_trainer.sv
// Turns a reported conflict pair into a table write.
// Classifies the pair by which sides already own a set, picks the
// identifier to store in both entries, and owns the wrapping allocation
// counter used for brand-new sets.
// Assumes: the table reads a/b reflect state before this cycle's edge.
module cset_trainer
    import cset_pkg::*;
#(
    parameter int unsigned SID_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             trn_vld_i,
    input  logic             a_vld_i,
    input  logic [SID_W-1:0] a_sid_i,
    input  logic             b_vld_i,
    input  logic [SID_W-1:0] b_sid_i,
    output logic             wr_en_o,
    output logic [SID_W-1:0] wr_sid_o,
    output logic             alloc_en_o,
    output logic [SID_W-1:0] alloc_q_o
);

    trn_case_e        tcase;
    logic [SID_W-1:0] alloc_q;

    // Classify the pair by set ownership
    always_comb begin
        unique case ({a_vld_i, b_vld_i})
            2'b00:   tcase = TRN_NEW;
            2'b10:   tcase = TRN_ADOPT_A;
            2'b01:   tcase = TRN_ADOPT_B;
            default: tcase = TRN_MERGE;
        endcase
    end

    // Choose the identifier both entries receive
    always_comb begin
        unique case (tcase)
            TRN_NEW:     wr_sid_o = alloc_q;
            TRN_ADOPT_A: wr_sid_o = a_sid_i;
            TRN_ADOPT_B: wr_sid_o = b_sid_i;
            default:     wr_sid_o = (a_sid_i < b_sid_i) ? a_sid_i : b_sid_i;
        endcase
    end

    assign wr_en_o    = trn_vld_i && !clr_i;
    assign alloc_en_o = wr_en_o && (tcase == TRN_NEW);

    // Allocation counter: restarts on sweep, wraps naturally at its width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '0;
        end else if (clr_i) begin
            alloc_q <= '0;
        end else if (alloc_en_o) begin
            alloc_q <= alloc_q + 1'b1;
        end
    end

    assign alloc_q_o = alloc_q;

endmodule

// File: rtl/cset_sweep.sv
// Free-running period counter that raises a one-cycle clear pulse in the
// last cycle of every PERIOD-cycle window after reset release.
// Assumes: PERIOD >= 2.
module cset_sweep #(
    parameter int unsigned PERIOD = 65536
) (
    input  logic clk,
    input  logic rst_n,
    output logic clr_o
);

    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign clr_o = (cnt_q == LAST);

    // Count cycles since reset, restarting after each sweep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cset_issue.sv
// Issue-group filter: grants candidates in slot order and holds back any
// candidate that shares a set with an older candidate already granted in
// the same cycle. Candidates without a set are never held back.
// Assumes: slot 0 is the oldest candidate.
module cset_issue #(
    parameter int unsigned ISSUE_W = 3,
    parameter int unsigned SID_W   = 7
) (
    input  logic [ISSUE_W-1:0]       vld_i,
    input  logic [ISSUE_W-1:0]       set_vld_i,
    input  logic [ISSUE_W*SID_W-1:0] sid_i,
    output logic [ISSUE_W-1:0]       go_o
);

    // Walk the slots oldest first, comparing against earlier grants only
    always_comb begin
        logic [ISSUE_W-1:0] g;
        logic               blk;
        g = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            blk = 1'b0;
            for (int j = 0; j < k; j++) begin
                if (g[j] && set_vld_i[j] && set_vld_i[k] &&
                    (sid_i[j*SID_W +: SID_W] == sid_i[k*SID_W +: SID_W])) begin
                    blk = 1'b1;
                end
            end
            g[k] = vld_i[k] && !blk;
        end
        go_o = g;
    end

endmodule

// File: rtl/cset_predictor.sv
// Conflict-set predictor top. Maps instruction addresses to table indices,
// shares one set table between the lookup port, the two training reads
// and the issue slots, and wires the trainer, sweep and issue filter.
// Assumes: instruction addresses are word aligned (PC_LSB low bits ignored).
module cset_predictor #(
    parameter int unsigned PC_W         = 32,
    parameter int unsigned IDX_W        = 10,
    parameter int unsigned PC_LSB       = 2,
    parameter int unsigned SID_W        = 7,
    parameter int unsigned ISSUE_W      = 3,
    parameter int unsigned CLEAR_PERIOD = 65536
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       lk_pc_i,
    output logic                  lk_vld_o,
    output logic [SID_W-1:0]      lk_sid_o,
    input  logic                  trn_vld_i,
    input  logic [PC_W-1:0]       trn_pc_a_i,
    input  logic [PC_W-1:0]       trn_pc_b_i,
    input  logic [ISSUE_W-1:0]    iss_vld_i,
    input  logic [ISSUE_W*PC_W-1:0] iss_pc_i,
    output logic [ISSUE_W-1:0]    iss_go_o
);

    localparam int unsigned P_LK  = 0;
    localparam int unsigned P_TA  = 1;
    localparam int unsigned P_TB  = 2;
    localparam int unsigned P_IS  = 3;
    localparam int unsigned NRD   = P_IS + ISSUE_W;

    logic [NRD*IDX_W-1:0] rd_idx;
    logic [NRD-1:0]       rd_vld;
    logic [NRD*SID_W-1:0] rd_sid;

    logic                 clr_pulse;
    logic                 wr_en;
    logic [SID_W-1:0]     wr_sid;
    logic                 alloc_en;
    logic [SID_W-1:0]     alloc_q;

    logic                 unused_pc;
    assign unused_pc = ^{lk_pc_i, trn_pc_a_i, trn_pc_b_i, iss_pc_i, alloc_en, alloc_q};

    // Index extraction for every read port
    assign rd_idx[P_LK*IDX_W +: IDX_W] = lk_pc_i[PC_LSB +: IDX_W];
    assign rd_idx[P_TA*IDX_W +: IDX_W] = trn_pc_a_i[PC_LSB +: IDX_W];
    assign rd_idx[P_TB*IDX_W +: IDX_W] = trn_pc_b_i[PC_LSB +: IDX_W];
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_iss_idx
        assign rd_idx[(P_IS+s)*IDX_W +: IDX_W] = iss_pc_i[s*PC_W + PC_LSB +: IDX_W];
    end

    cset_table #(
        .IDX_W (IDX_W),
        .SID_W (SID_W),
        .NRD   (NRD)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_pulse),
        .rd_idx_i   (rd_idx),
        .rd_vld_o   (rd_vld),
        .rd_sid_o   (rd_sid),
        .wr_en_i    (wr_en),
        .wr_idx_a_i (trn_pc_a_i[PC_LSB +: IDX_W]),
        .wr_idx_b_i (trn_pc_b_i[PC_LSB +: IDX_W]),
        .wr_sid_i   (wr_sid)
    );

    cset_trainer #(
        .SID_W (SID_W)
    ) u_trainer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_pulse),
        .trn_vld_i  (trn_vld_i),
        .a_vld_i    (rd_vld[P_TA]),
        .a_sid_i    (rd_sid[P_TA*SID_W +: SID_W]),
        .b_vld_i    (rd_vld[P_TB]),
        .b_sid_i    (rd_sid[P_TB*SID_W +: SID_W]),
        .wr_en_o    (wr_en),
        .wr_sid_o   (wr_sid),
        .alloc_en_o (alloc_en),
        .alloc_q_o  (alloc_q)
    );

    cset_sweep #(
        .PERIOD (CLEAR_PERIOD)
    ) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_o (clr_pulse)
    );

    cset_issue #(
        .ISSUE_W (ISSUE_W),
        .SID_W   (SID_W)
    ) u_issue (
        .vld_i     (iss_vld_i),
        .set_vld_i (rd_vld[P_IS +: ISSUE_W]),
        .sid_i     (rd_sid[P_IS*SID_W +: ISSUE_W*SID_W]),
        .go_o      (iss_go_o)
    );

    assign lk_vld_o = rd_vld[P_LK];
    assign lk_sid_o = rd_sid[P_LK*SID_W +: SID_W];

endmodule

// File: rtl/cset_predictor_chk.sv
// Property checker for cset_predictor, attached with bind below.
// Observes ports plus the sweep pulse and allocation counter.
module cset_predictor_chk #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned PC_LSB  = 2,
    parameter int unsigned SID_W   = 7,
    parameter int unsigned ISSUE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    lk_pc_i,
    input logic               lk_vld_o,
    input logic               trn_vld_i,
    input logic [PC_W-1:0]    trn_pc_a_i,
    input logic [ISSUE_W-1:0] iss_vld_i,
    input logic [ISSUE_W-1:0] iss_go_o,
    input logic               clr_pulse,
    input logic               alloc_en,
    input logic [SID_W-1:0]   alloc_q
);

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] ta_idx;
    logic             unused_chk;
    assign lk_idx = lk_pc_i[PC_LSB +: IDX_W];
    assign ta_idx = trn_pc_a_i[PC_LSB +: IDX_W];
    assign unused_chk = ^{lk_pc_i, trn_pc_a_i};

    // R6
    go_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go_o & ~iss_vld_i) == '0);

    // R5
    oldest_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_i[0] |-> iss_go_o[0]);

    // R2
    trained_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trn_vld_i) && !$past(clr_pulse) &&
         (lk_idx == $past(ta_idx))) |-> lk_vld_o);

    // R9
    swept_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_pulse)) |-> !lk_vld_o);

    // R8
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_en)) |-> (alloc_q == SID_W'($past(alloc_q) + 1'b1)));

endmodule

bind cset_predictor cset_predictor_chk #(
    .PC_W    (PC_W),
    .IDX_W   (IDX_W),
    .PC_LSB  (PC_LSB),
    .SID_W   (SID_W),
    .ISSUE_W (ISSUE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc_i    (lk_pc_i),
    .lk_vld_o   (lk_vld_o),
    .trn_vld_i  (trn_vld_i),
    .trn_pc_a_i (trn_pc_a_i),
    .iss_vld_i  (iss_vld_i),
    .iss_go_o   (iss_go_o),
    .clr_pulse  (clr_pulse),
    .alloc_en   (alloc_en),
    .alloc_q    (alloc_q)
);

// File: tb/test_cset_predictor.sv
// Scoreboard bench: the driver pushes expected lookup/grant results into a
// queue right after applying stimulus; the monitor pops and compares them
// 2 ns later, well before the next rising edge.
module test_cset_predictor;

    localparam int PC_W = 32;
    localparam int SID_W = 7;
    localparam int ISSUE_W = 3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [PC_W-1:0]          lk_pc_i = '0;
    logic                     lk_vld_o;
    logic [SID_W-1:0]         lk_sid_o;
    logic                     trn_vld_i = 1'b0;
    logic [PC_W-1:0]          trn_pc_a_i = '0;
    logic [PC_W-1:0]          trn_pc_b_i = '0;
    logic [ISSUE_W-1:0]       iss_vld_i = '0;
    logic [ISSUE_W*PC_W-1:0]  iss_pc_i = '0;
    logic [ISSUE_W-1:0]       iss_go_o;

    always #5 clk = ~clk;

    cset_predictor i_cset_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc_i    (lk_pc_i),
        .lk_vld_o   (lk_vld_o),
        .lk_sid_o   (lk_sid_o),
        .trn_vld_i  (trn_vld_i),
        .trn_pc_a_i (trn_pc_a_i),
        .trn_pc_b_i (trn_pc_b_i),
        .iss_vld_i  (iss_vld_i),
        .iss_pc_i   (iss_pc_i),
        .iss_go_o   (iss_go_o)
    );

    typedef struct {
        bit               chk_lk;
        bit               exp_v;
        logic [SID_W-1:0] exp_sid;
        bit               chk_go;
        logic [ISSUE_W-1:0] exp_go;
        string            tag;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    ecount  = 0;
    bit    done    = 1'b0;

    // Rising edges since reset release
    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    function automatic logic [PC_W-1:0] pc(input int i);
        return 32'h4000_0000 + PC_W'(i * 4);
    endfunction

    task automatic tick();
        @(negedge clk);
        trn_vld_i = 1'b0;
        iss_vld_i = '0;
    endtask

    task automatic exp_lk(input logic [PC_W-1:0] p, input bit v, input int sid, input string tag);
        item_t it;
        lk_pc_i = p;
        it.chk_lk = 1'b1; it.exp_v = v; it.exp_sid = SID_W'(sid);
        it.chk_go = 1'b0; it.exp_go = '0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_go(input logic [ISSUE_W-1:0] v, input logic [PC_W-1:0] p0,
                          input logic [PC_W-1:0] p1, input logic [PC_W-1:0] p2,
                          input logic [ISSUE_W-1:0] g, input string tag);
        item_t it;
        iss_vld_i = v;
        iss_pc_i  = {p2, p1, p0};
        it.chk_lk = 1'b0; it.exp_v = 1'b0; it.exp_sid = '0;
        it.chk_go = 1'b1; it.exp_go = g; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic train(input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
        trn_vld_i = 1'b1; trn_pc_a_i = a; trn_pc_b_i = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk_lk) begin
                    n_tests++;
                    if (lk_vld_o !== it.exp_v || (it.exp_v && lk_sid_o !== it.exp_sid)) begin
                        n_fail++;
                        $display("FAIL %s: lookup vld=%0b sid=%0d expected vld=%0b sid=%0d",
                                 it.tag, lk_vld_o, lk_sid_o, it.exp_v, it.exp_sid);
                    end
                end
                if (it.chk_go) begin
                    n_tests++;
                    if (iss_go_o !== it.exp_go) begin
                        n_fail++;
                        $display("FAIL %s: grant=%b expected=%b", it.tag, iss_go_o, it.exp_go);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset, all candidates granted
        exp_lk(pc(1), 1'b0, 0, "R1 empty after reset");
        exp_go(3'b111, pc(1), pc(2), pc(3), 3'b111, "R1 all granted after reset");

        // R2: fresh pair gets id 0
        tick(); train(pc(1), pc(2));
        tick(); exp_lk(pc(1), 1'b1, 0, "R2 new set side a");
        tick(); exp_lk(pc(2), 1'b1, 0, "R2 new set side b");
        tick(); train(pc(3), pc(4));
        tick(); exp_lk(pc(4), 1'b1, 1, "R2 second new set");

        // R3: one side already owns a set
        tick(); train(pc(5), pc(1));
        tick(); exp_lk(pc(5), 1'b1, 0, "R3 joins existing set");
        tick(); exp_lk(pc(1), 1'b1, 0, "R3 owner unchanged");

        // R4: merge keeps the smaller id, other members untouched
        tick(); train(pc(3), pc(2));
        tick(); exp_lk(pc(3), 1'b1, 0, "R4 merge picks smaller id");
        tick(); exp_lk(pc(2), 1'b1, 0, "R4 merge other side");
        tick(); exp_lk(pc(4), 1'b1, 1, "R4 non-member keeps larger id");

        // R2/R3: counter did not advance on adopt/merge
        tick(); train(pc(6), pc(7));
        tick(); exp_lk(pc(7), 1'b1, 2, "R3 counter held on adopt and merge");

        // R5: issue filtering (sets: 1,2,3,5 -> 0; 4 -> 1)
        tick(); exp_go(3'b111, pc(1), pc(5), pc(4), 3'b101, "R5 same set held");
        tick(); exp_go(3'b111, pc(4), pc(1), pc(3), 3'b011, "R5 held by granted slot1");
        tick(); exp_go(3'b111, pc(10), pc(11), pc(12), 3'b111, "R5 no set never held");
        tick(); exp_go(3'b111, pc(1), pc(1), pc(4), 3'b101, "R5 same pc twice");

        // R6: invalid slots neither granted nor blocking
        tick(); exp_go(3'b110, pc(1), pc(5), pc(2), 3'b010, "R6 invalid slot0 ignored");
        tick(); exp_go(3'b101, pc(1), pc(5), pc(2), 3'b001, "R6 invalid slot1 not granted");

        // R7: same-cycle training not yet visible
        tick(); train(pc(10), pc(11));
        exp_lk(pc(10), 1'b0, 0, "R7 lookup sees old state");
        exp_go(3'b111, pc(10), pc(11), pc(1), 3'b111, "R7 issue sees old state");
        tick(); exp_lk(pc(10), 1'b1, 3, "R7 update visible next cycle");
        tick(); exp_go(3'b111, pc(10), pc(11), pc(1), 3'b101, "R7 issue after update");

        // R10: aliasing addresses share one entry
        tick(); exp_lk(pc(1) + 32'h0000_1000, 1'b1, 0, "R10 alias shares entry");
        tick(); exp_lk(pc(1) + 32'h0000_0001, 1'b1, 0, "R10 low bits ignored");

        // R9: periodic sweep at edge 65536, discarding same-cycle training
        while (ecount != 65535) tick();
        train(pc(30), pc(31));
        exp_lk(pc(1), 1'b1, 0, "R9 still valid before sweep");
        tick(); exp_lk(pc(1), 1'b0, 0, "R9 emptied by sweep");
        tick(); exp_lk(pc(30), 1'b0, 0, "R9 training in sweep cycle discarded");

        // R8/R9: counter restarts at 0, then wraps after 127
        for (int k = 0; k < 129; k++) begin
            tick(); train(pc(200 + 2*k), pc(201 + 2*k));
            tick(); exp_lk(pc(201 + 2*k), 1'b1, k % 128, "R8 allocation sequence and wrap");
        end

        tick(); tick();
        finish_run();
    end

endmodule